// File: doc/BRIEF.md
# Shadow Store/Recall Transfer Controller

This block holds a byte-wide volatile working array and a nonvolatile shadow array of the same size. Both are register arrays written so that block RAM can be inferred. A host reads and writes the working array through a simple enable/write-enable port. Three triggers copy data between the two arrays. A store request erases the shadow to all-ones and then programs it with every working byte. A recall request copies the shadow back into the working array. A power-restore event starts the same recall without any host request.

While a transfer runs, `busy` is high and every host access is ignored. A power-restore event that arrives during a store is held, and its recall runs straight after the store, with no idle cycle between them. The sequence detector that produces the store and recall requests sits outside this block.

Top module: `shadow_xfer_ctrl`

## Requirements
- R1: After a synchronous reset, `busy` is 0 and `host_rdata` is 0.
- R2: While `busy` is 0, a host write (`host_en`=1, `host_we`=1) updates the addressed byte. A host read (`host_en`=1, `host_we`=0) presents that byte on `host_rdata` two clock edges after the edge that samples it, and `host_rdata` does not change on the first of those edges.
- R3: A store captures every working byte. A later recall restores those values, even at addresses the host has changed since the store.
- R4: A store request sampled while idle raises `busy` from the next cycle. `busy` then stays high for 2*DEPTH+1 cycles (4097 by default): DEPTH erase cycles, DEPTH program cycles and one write-back cycle.
- R5: A recall request sampled while idle keeps `busy` high for DEPTH+1 cycles (2049 by default) and rewrites the working array from the shadow.
- R6: A power-restore event sampled while idle performs the same recall as R5, with no host request.
- R7: A host write issued while `busy` is 1 has no effect on the working array.
- R8: A host read issued while `busy` is 1 is ignored, and `host_rdata` keeps its value.
- R9: A store or recall request that arrives while `busy` is 1 is ignored, and the running transfer keeps its length.
- R10: A power-restore event during a store is queued. `busy` stays high without a break for 3*DEPTH+2 cycles (6146 by default), and the queued recall brings back the data just stored.
- R11: When store and recall (or power restore) are sampled in the same idle cycle, the recall runs and the store is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en | input | 1 | Host access enable |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Registered host read data |
| store_req | input | 1 | One-cycle store trigger |
| recall_req | input | 1 | One-cycle recall trigger |
| pwr_restore | input | 1 | One-cycle power-restore event |
| busy | output | 1 | Transfer in progress, host locked out |

## Verification
Every result has a fixed delay in clock edges. Read data appears on the second edge after the read is sampled. `busy` rises on the edge that samples a request and then stays high for exactly 4097, 2049 or 6146 cycles, depending on the transfer. The bench drives inputs and samples outputs on falling edges. It counts falling edges while `busy` is high and compares that count with the exact figure, so an extra or missing cycle in any phase shows up. Lockout results are read once `busy` has fallen: the bench either reads the untouched address back or compares `host_rdata` with the value it held before the transfer.

// File: rtl/shadow_xfer_pkg.sv
package shadow_xfer_pkg;
  typedef enum logic [2:0] {
    XS_IDLE,
    XS_ERASE,
    XS_PROG,
    XS_RECALL,
    XS_DRAIN
  } xfer_state_t;
endpackage

// File: rtl/sxc_ram.sv
module sxc_ram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // synchronous read port, read-before-write
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sxc_sequencer.sv
module sxc_sequencer
  import shadow_xfer_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              store_req,
  input  logic              recall_req,
  input  logic              pwr_restore,
  output logic              busy,
  output logic              erase_en,
  output logic              rd_en,
  output logic              rd_from_shadow,
  output logic [ADDR_W-1:0] sweep_addr,
  output logic              wb_en,
  output logic              wb_to_work,
  output logic [ADDR_W-1:0] wb_addr
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  xfer_state_t       state;
  logic [ADDR_W-1:0] idx;
  logic              restore_pend;
  logic              in_store;

  assign in_store = (state == XS_ERASE) || (state == XS_PROG) ||
                    ((state == XS_DRAIN) && !wb_to_work);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= XS_IDLE;
      idx          <= '0;
      restore_pend <= 1'b0;
      wb_en        <= 1'b0;
      wb_to_work   <= 1'b0;
      wb_addr      <= '0;
    end else begin
      // one-cycle write-back pipe behind the synchronous source read
      wb_en      <= (state == XS_PROG) || (state == XS_RECALL);
      wb_to_work <= (state == XS_RECALL);
      wb_addr    <= idx;

      if (in_store && pwr_restore) restore_pend <= 1'b1;

      case (state)
        XS_IDLE: begin
          idx <= '0;
          if (recall_req || pwr_restore) state <= XS_RECALL;
          else if (store_req)            state <= XS_ERASE;
        end
        XS_ERASE: begin
          idx <= idx + 1'b1;
          if (idx == LAST) state <= XS_PROG;
        end
        XS_PROG: begin
          idx <= idx + 1'b1;
          if (idx == LAST) state <= XS_DRAIN;
        end
        XS_RECALL: begin
          idx <= idx + 1'b1;
          if (idx == LAST) state <= XS_DRAIN;
        end
        XS_DRAIN: begin
          idx <= '0;
          if (restore_pend || (pwr_restore && !wb_to_work)) begin
            state        <= XS_RECALL;
            restore_pend <= 1'b0;
          end else begin
            state <= XS_IDLE;
          end
        end
        default: state <= XS_IDLE;
      endcase
    end
  end

  assign busy           = (state != XS_IDLE);
  assign erase_en       = (state == XS_ERASE);
  assign rd_en          = (state == XS_PROG) || (state == XS_RECALL);
  assign rd_from_shadow = (state == XS_RECALL);
  assign sweep_addr     = idx;
endmodule

// File: rtl/shadow_xfer_ctrl.sv
module shadow_xfer_ctrl #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_en,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              store_req,
  input  logic              recall_req,
  input  logic              pwr_restore,
  output logic              busy
);
  localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

  logic              erase_en, rd_en, rd_from_shadow, wb_en, wb_to_work;
  logic [ADDR_W-1:0] sweep_addr, wb_addr;
  logic              host_rd, host_wr, host_rd_q;

  logic              wk_we, wk_re, sh_we, sh_re;
  logic [ADDR_W-1:0] wk_waddr, wk_raddr, sh_waddr;
  logic [DATA_W-1:0] wk_wdata, wk_dout, sh_wdata, sh_dout;

  sxc_sequencer #(.ADDR_W(ADDR_W)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .store_req     (store_req),
    .recall_req    (recall_req),
    .pwr_restore   (pwr_restore),
    .busy          (busy),
    .erase_en      (erase_en),
    .rd_en         (rd_en),
    .rd_from_shadow(rd_from_shadow),
    .sweep_addr    (sweep_addr),
    .wb_en         (wb_en),
    .wb_to_work    (wb_to_work),
    .wb_addr       (wb_addr)
  );

  // host gets the ports only while no transfer runs
  assign host_rd = !busy && host_en && !host_we;
  assign host_wr = !busy && host_en && host_we;

  assign wk_we    = busy ? (wb_en && wb_to_work) : host_wr;
  assign wk_waddr = busy ? wb_addr : host_addr;
  assign wk_wdata = busy ? sh_dout : host_wdata;
  assign wk_re    = busy ? (rd_en && !rd_from_shadow) : host_rd;
  assign wk_raddr = busy ? sweep_addr : host_addr;

  assign sh_we    = erase_en || (wb_en && !wb_to_work);
  assign sh_waddr = erase_en ? sweep_addr : wb_addr;
  assign sh_wdata = erase_en ? ERASED : wk_dout;
  assign sh_re    = rd_en && rd_from_shadow;

  sxc_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_work (
    .clk  (clk),
    .we   (wk_we),
    .waddr(wk_waddr),
    .wdata(wk_wdata),
    .re   (wk_re),
    .raddr(wk_raddr),
    .rdata(wk_dout)
  );

  sxc_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shadow (
    .clk  (clk),
    .we   (sh_we),
    .waddr(sh_waddr),
    .wdata(sh_wdata),
    .re   (sh_re),
    .raddr(sweep_addr),
    .rdata(sh_dout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rd_q  <= 1'b0;
      host_rdata <= '0;
    end else begin
      host_rd_q <= host_rd;
      if (host_rd_q) host_rdata <= wk_dout;
    end
  end
endmodule

// File: rtl/shadow_xfer_checker.sv
module shadow_xfer_checker #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              store_req,
  input logic              recall_req,
  input logic              pwr_restore,
  input logic              busy,
  input logic [DATA_W-1:0] host_rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = ADDR_W + 3;

  logic [CW-1:0] run_len;
  logic          any_req;

  assign any_req = store_req || recall_req || pwr_restore;

  always_ff @(posedge clk) begin
    if (rst)                  run_len <= '0;
    else if (!busy)           run_len <= '0;
    else if (run_len != '1)   run_len <= run_len + 1'b1;
  end

  // R4: an idle request starts a transfer on the next cycle
  p_req_starts_r4: assert property (@(posedge clk) disable iff (rst)
    (!busy && any_req) |=> busy);

  // R9: with no request the block stays idle
  p_idle_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !any_req) |=> !busy);

  // R8: read data is frozen during a transfer
  p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |=> $stable(host_rdata));

  // R5: no transfer is shorter than a full recall sweep
  p_min_busy_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len >= CW'(DEPTH + 1)));

  // R10: a store plus a queued recall is the longest run
  p_max_busy_r10: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_len <= CW'(3 * DEPTH + 2)));
endmodule

bind shadow_xfer_ctrl shadow_xfer_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .store_req  (store_req),
  .recall_req (recall_req),
  .pwr_restore(pwr_restore),
  .busy       (busy),
  .host_rdata (host_rdata)
);

// File: tb/shadow_xfer_ctrl_test.sv
module shadow_xfer_ctrl_test;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_en = 1'b0, host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata;
  logic          store_req = 1'b0, recall_req = 1'b0, pwr_restore = 1'b0;
  logic          busy;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  shadow_xfer_ctrl #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .host_en(host_en), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .store_req(store_req), .recall_req(recall_req), .pwr_restore(pwr_restore),
    .busy(busy)
  );

  function automatic logic [DW-1:0] pat_a(input int a);
    return DW'(a * 7 + 3);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
    @(negedge clk);
    host_en = 1'b0; host_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b0; host_addr = AW'(a);
    @(negedge clk);
    host_en = 1'b0;
    @(negedge clk);
    d = host_rdata;
  endtask

  // pulse triggers, optionally inject one cycle of stimulus mid-transfer,
  // return the number of cycles busy stayed high
  task automatic xfer(input bit s, input bit r, input bit p, input int inj_at,
                      input bit is, input bit ir, input bit ip,
                      input bit ien, input bit iwe, input int ia,
                      input logic [DW-1:0] id, output int len);
    @(negedge clk);
    store_req = s; recall_req = r; pwr_restore = p;
    @(negedge clk);
    store_req = 1'b0; recall_req = 1'b0; pwr_restore = 1'b0;
    len = 0;
    while (busy) begin
      if (len == inj_at) begin
        store_req = is; recall_req = ir; pwr_restore = ip;
        host_en = ien; host_we = iwe; host_addr = AW'(ia); host_wdata = id;
      end else begin
        store_req = 1'b0; recall_req = 1'b0; pwr_restore = 1'b0;
        host_en = 1'b0; host_we = 1'b0;
      end
      len++;
      @(negedge clk);
    end
    store_req = 1'b0; recall_req = 1'b0; pwr_restore = 1'b0;
    host_en = 1'b0; host_we = 1'b0;
  endtask

  task automatic t_reset;
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(host_rdata == '0, "R1 rdata after reset", int'(host_rdata), 0);
  endtask

  task automatic t_host_rw;
    logic [DW-1:0] d;
    for (int a = 0; a < DEPTH; a++) wr(a, pat_a(a));
    rd(0, d);
    check(d == pat_a(0), "R2 read addr 0", int'(d), int'(pat_a(0)));
    rd(2047, d);
    check(d == pat_a(2047), "R2 read addr 2047", int'(d), int'(pat_a(2047)));
    // latency: not yet updated after first edge
    @(negedge clk);
    host_en = 1'b1; host_we = 1'b0; host_addr = AW'(1);
    @(negedge clk);
    host_en = 1'b0;
    check(host_rdata == pat_a(2047), "R2 rdata holds one edge", int'(host_rdata), int'(pat_a(2047)));
    @(negedge clk);
    check(host_rdata == pat_a(1), "R2 rdata after two edges", int'(host_rdata), int'(pat_a(1)));
  endtask

  task automatic t_store_recall;
    int len;
    logic [DW-1:0] d;
    xfer(1, 0, 0, -1, 0, 0, 0, 0, 0, 0, 0, len);
    check(len == 2 * DEPTH + 1, "R4 store busy length", len, 2 * DEPTH + 1);
    wr(0, 8'h5A); wr(5, 8'hC3); wr(2047, 8'h11);
    rd(5, d);
    check(d == 8'hC3, "R2 modified byte", int'(d), 'hC3);
    xfer(0, 1, 0, -1, 0, 0, 0, 0, 0, 0, 0, len);
    check(len == DEPTH + 1, "R5 recall busy length", len, DEPTH + 1);
    rd(0, d);
    check(d == pat_a(0), "R3 recall restores addr 0", int'(d), int'(pat_a(0)));
    rd(5, d);
    check(d == pat_a(5), "R5 recall restores addr 5", int'(d), int'(pat_a(5)));
    rd(2047, d);
    check(d == pat_a(2047), "R3 recall restores addr 2047", int'(d), int'(pat_a(2047)));
  endtask

  task automatic t_pwr_idle;
    int len;
    logic [DW-1:0] d;
    wr(9, 8'hEE);
    xfer(0, 0, 1, -1, 0, 0, 0, 0, 0, 0, 0, len);
    check(len == DEPTH + 1, "R6 restore busy length", len, DEPTH + 1);
    rd(9, d);
    check(d == pat_a(9), "R6 restore data", int'(d), int'(pat_a(9)));
  endtask

  task automatic t_write_busy;
    int len;
    logic [DW-1:0] d;
    xfer(1, 0, 0, 50, 0, 0, 0, 1, 1, 12, ~pat_a(12), len);
    check(len == 2 * DEPTH + 1, "R7 store length with write", len, 2 * DEPTH + 1);
    rd(12, d);
    check(d == pat_a(12), "R7 busy write ignored", int'(d), int'(pat_a(12)));
  endtask

  task automatic t_read_busy;
    int len;
    logic [DW-1:0] d;
    rd(3, d);
    xfer(0, 1, 0, 10, 0, 0, 0, 1, 0, 4, 0, len);
    check(host_rdata == pat_a(3), "R8 busy read ignored", int'(host_rdata), int'(pat_a(3)));
  endtask

  task automatic t_req_busy;
    int len;
    xfer(0, 1, 0, 100, 1, 0, 0, 0, 0, 0, 0, len);
    check(len == DEPTH + 1, "R9 store during recall ignored", len, DEPTH + 1);
    xfer(1, 0, 0, 100, 0, 1, 0, 0, 0, 0, 0, len);
    check(len == 2 * DEPTH + 1, "R9 recall during store ignored", len, 2 * DEPTH + 1);
  endtask

  task automatic t_queued;
    int len;
    logic [DW-1:0] d;
    wr(20, 8'hB7);
    xfer(1, 0, 0, 200, 0, 0, 1, 0, 0, 0, 0, len);
    check(len == 3 * DEPTH + 2, "R10 queued restore length", len, 3 * DEPTH + 2);
    rd(20, d);
    check(d == 8'hB7, "R10 stored data recalled", int'(d), 'hB7);
  endtask

  task automatic t_priority;
    int len;
    logic [DW-1:0] d;
    wr(30, 8'h3C);
    xfer(1, 1, 0, -1, 0, 0, 0, 0, 0, 0, 0, len);
    check(len == DEPTH + 1, "R11 recall wins length", len, DEPTH + 1);
    rd(30, d);
    check(d == pat_a(30), "R11 recall wins data", int'(d), int'(pat_a(30)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_host_rw;
    t_store_recall;
    t_pwr_idle;
    t_write_busy;
    t_read_busy;
    t_req_busy;
    t_queued;
    t_priority;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule